// File: doc/BRIEF.md
# Dual-Mode Clock Gate Controller

This block decides whether one peripheral clock runs, and drives a clock-enable output for a separate glitch-free gating cell. Control comes from one 32-bit register. A mode bit chooses between hardware auto-gating and software gating. In hardware mode, an external run-request input opens and closes the gate. In software mode, an enable bit in the register does.

A read-only status bit in the same register reports the real state of the gate. It trails the clock-enable output by a short synchronisation delay, so software that changes the mode or the enable can poll this bit until the gate has settled.

Two build-time options change the policy. A keep-on variant never stops the clock while it is under software control, and still lets hardware mode gate it. A gateless variant holds the clock enable high at all times, whatever the register and the request input say.

Top module: `clkgate_ctrl`

## Requirements
- R1: After reset the register reads 32'h0000_0007: mode bit 2 = 1 (software), enable bit 0 = 1, status bit 1 = 1. `clk_en` is 1.
- R2: When `wr_en` is high at a clock edge, bit 2 (mode) and bit 0 (enable) of `wr_data` are stored, and `rd_data` shows them from that edge onward.
- R3: In software mode (mode bit = 1) on a gated build without keep-on, `clk_en` equals the stored enable bit, one cycle after it is stored.
- R4: In hardware mode (mode bit = 0) on a gated build, `clk_en` equals `hw_run` as sampled at the previous clock edge.
- R5: Status bit 1 of `rd_data` equals `clk_en` as it was two clock cycles earlier, so a change of `clk_en` is visible to software two cycles later.
- R6: Writes to the status bit have no effect on it. All register bits other than 0, 1 and 2 read as 0 whatever is written.
- R7: With the keep-on option, `clk_en` stays 1 in software mode even when the enable bit is 0. In hardware mode it still follows `hw_run`.
- R8: With the gateless option, `clk_en` is 1 at all times, whatever the register or `hw_run` hold.
- R9: The mode can change at run time. After a write that changes the mode, the newly selected source drives `clk_en` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock of the peripheral; all state is clocked on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value: mode, enable and status bits |
| hw_run | input | 1 | Hardware run request, used in hardware mode (1 = clock needed) |
| clk_en | output | 1 | Enable for the external clock-gating cell |

## Verification
The bench counts the cycles from a write to the `clk_en` change, and from there to the status change. A design that compared status to the live `clk_en`, or that used the wrong number of synchroniser stages, would show the new status early or late. It writes a 1 to the status bit while the gate is closed, and writes all ones to the register. A design that stored the status bit or kept spare bits would read back a wrong value. It switches between hardware and software modes while `hw_run` and the enable bit disagree, so a design that kept the old source for a cycle, or that honoured the enable bit in keep-on mode, would show the wrong enable. It also builds the gateless variant, which must hold `clk_en` high through every write.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
    localparam int unsigned CSR_W = 32;

    typedef struct packed {
        logic sw_mode;
        logic sw_en;
    } gate_ctl_t;
endpackage

// File: rtl/clkgate_csr.sv
module clkgate_csr
    import clkgate_pkg::*;
#(
    parameter int unsigned EN_POS  = 0,
    parameter int unsigned SEL_POS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    output gate_ctl_t        ctl
);
    gate_ctl_t ctl_d, ctl_q;

    // Only the mode and enable bits are writable; the others are dropped.
    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.sw_mode = wr_data[SEL_POS];
            ctl_d.sw_en   = wr_data[EN_POS];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{sw_mode: 1'b1, sw_en: 1'b1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/clkgate_policy.sv
module clkgate_policy
    import clkgate_pkg::*;
#(
    parameter bit HAS_GATE = 1'b1,
    parameter bit KEEP_ON  = 1'b0
) (
    input  gate_ctl_t ctl,
    input  logic      hw_run,
    output logic      want_on
);
    always_comb begin
        if (!HAS_GATE) begin
            want_on = 1'b1;
        end else if (ctl.sw_mode) begin
            want_on = ctl.sw_en | KEEP_ON;
        end else begin
            want_on = hw_run;
        end
    end
endmodule

// File: rtl/clkgate_track.sv
module clkgate_track #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_on,
    output logic clk_en,
    output logic settled
);
    typedef struct packed {
        logic              gate;
        logic [STAGES-1:0] pipe;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [STAGES-1:0] pipe_next;

    generate
        if (STAGES == 1) begin : g_one
            assign pipe_next = trk_q.gate;
        end else begin : g_many
            assign pipe_next = {trk_q.pipe[STAGES-2:0], trk_q.gate};
        end
    endgenerate

    always_comb begin
        trk_d      = trk_q;
        trk_d.gate = want_on;
        trk_d.pipe = pipe_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '{gate: 1'b1, pipe: '1};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign clk_en  = trk_q.gate;
    assign settled = trk_q.pipe[STAGES-1];
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
    import clkgate_pkg::*;
#(
    parameter int unsigned EN_POS      = 0,
    parameter int unsigned STAT_POS    = 1,
    parameter int unsigned SEL_POS     = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          HAS_GATE    = 1'b1,
    parameter bit          KEEP_ON     = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    output logic [CSR_W-1:0] rd_data,
    input  logic             hw_run,
    output logic             clk_en
);
    gate_ctl_t ctl;
    logic      want_on;
    logic      settled;

    clkgate_csr #(
        .EN_POS (EN_POS),
        .SEL_POS(SEL_POS)
    ) u_csr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .ctl    (ctl)
    );

    clkgate_policy #(
        .HAS_GATE(HAS_GATE),
        .KEEP_ON (KEEP_ON)
    ) u_policy (
        .ctl    (ctl),
        .hw_run (hw_run),
        .want_on(want_on)
    );

    clkgate_track #(
        .STAGES(SYNC_STAGES)
    ) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .want_on(want_on),
        .clk_en (clk_en),
        .settled(settled)
    );

    always_comb begin
        rd_data           = '0;
        rd_data[EN_POS]   = ctl.sw_en;
        rd_data[SEL_POS]  = ctl.sw_mode;
        rd_data[STAT_POS] = settled;
    end
endmodule

// File: rtl/clkgate_checks.sv
module clkgate_checks #(
    parameter int unsigned EN_POS      = 0,
    parameter int unsigned STAT_POS    = 1,
    parameter int unsigned SEL_POS     = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          HAS_GATE    = 1'b1,
    parameter bit          KEEP_ON     = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        hw_run,
    input logic [31:0] rd_data,
    input logic        clk_en
);
    localparam logic [31:0] LIVE_MASK =
        (32'd1 << EN_POS) | (32'd1 << STAT_POS) | (32'd1 << SEL_POS);

    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    a_r3_sw_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q != 2'd0 && HAS_GATE && !KEEP_ON && rd_data[SEL_POS])
        |=> (clk_en == $past(rd_data[EN_POS])));

    a_r4_hw_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q != 2'd0 && HAS_GATE && !rd_data[SEL_POS])
        |=> (clk_en == $past(hw_run)));

    generate
        if (SYNC_STAGES == 2) begin : g_lag
            a_r5_status_lag: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd2) |-> (rd_data[STAT_POS] == $past(clk_en, 2)));
        end
    endgenerate

    a_r6_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~LIVE_MASK) == 32'd0);

    a_r7_keep_on: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q != 2'd0 && HAS_GATE && KEEP_ON && rd_data[SEL_POS]) |=> clk_en);

    a_r8_ungated: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_GATE) |-> clk_en);
endmodule

bind clkgate_ctrl clkgate_checks #(
    .EN_POS     (EN_POS),
    .STAT_POS   (STAT_POS),
    .SEL_POS    (SEL_POS),
    .SYNC_STAGES(SYNC_STAGES),
    .HAS_GATE   (HAS_GATE),
    .KEEP_ON    (KEEP_ON)
) u_checks (
    .clk    (clk),
    .rst_n  (rst_n),
    .hw_run (hw_run),
    .rd_data(rd_data),
    .clk_en (clk_en)
);

// File: tb/clkgate_ctrl_test.sv
module clkgate_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = 32'd0;
    logic        hw_run = 1'b0;

    logic [31:0] rd_a, rd_k, rd_g;
    logic        en_a, en_k, en_g;

    int unsigned checks = 0;
    int unsigned errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    clkgate_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_a), .hw_run(hw_run), .clk_en(en_a)
    );

    clkgate_ctrl #(.KEEP_ON(1'b1)) uut_keep (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_k), .hw_run(hw_run), .clk_en(en_k)
    );

    clkgate_ctrl #(.HAS_GATE(1'b0)) uut_open (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_g), .hw_run(hw_run), .clk_en(en_g)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Write lands at the posedge between the two negedges.
    task automatic reg_write(input logic [31:0] val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = val;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 32'd0;
    endtask

    task automatic t_reset;
        chk("R1 reset value", rd_a, 32'h7);
        chk("R1 reset clk_en", {31'd0, en_a}, 32'd1);
        chk("R1 reset clk_en keep-on", {31'd0, en_k}, 32'd1);
    endtask

    task automatic t_sw_off_on;
        reg_write(32'h4);
        chk("R2 readback sw off", rd_a & 32'h5, 32'h4);
        chk("R3 clk_en not yet changed", {31'd0, en_a}, 32'd1);
        @(negedge clk);
        chk("R3 sw enable 0 closes gate", {31'd0, en_a}, 32'd0);
        chk("R5 status still old", {31'd0, rd_a[1]}, 32'd1);
        chk("R7 keep-on in sw mode", {31'd0, en_k}, 32'd1);
        @(negedge clk);
        chk("R5 status one cycle later still old", {31'd0, rd_a[1]}, 32'd1);
        @(negedge clk);
        chk("R5 status reports closed", {31'd0, rd_a[1]}, 32'd0);
        reg_write(32'h5);
        @(negedge clk);
        chk("R3 sw enable 1 opens gate", {31'd0, en_a}, 32'd1);
        @(negedge clk);
        @(negedge clk);
        chk("R5 status reports open", {31'd0, rd_a[1]}, 32'd1);
        chk("R2 readback sw on", rd_a, 32'h7);
    endtask

    task automatic t_status_ignored;
        reg_write(32'h4);
        repeat (4) @(negedge clk);
        reg_write(32'hFFFF_FFFE);
        chk("R6 status write ignored, spares zero", rd_a, 32'h4);
        repeat (3) @(negedge clk);
        chk("R6 status still closed", rd_a, 32'h4);
        chk("R6 gate still closed", {31'd0, en_a}, 32'd0);
        reg_write(32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        chk("R6 all-ones write reads 7", rd_a, 32'h7);
    endtask

    task automatic t_hw_mode;
        hw_run = 1'b0;
        reg_write(32'h0);
        chk("R2 readback hw mode", rd_a & 32'h5, 32'h0);
        @(negedge clk);
        chk("R4 hw idle closes gate", {31'd0, en_a}, 32'd0);
        chk("R7 keep-on gated in hw mode", {31'd0, en_k}, 32'd0);
        hw_run = 1'b1;
        chk("R4 registered, no change yet", {31'd0, en_a}, 32'd0);
        @(negedge clk);
        chk("R4 hw request opens gate", {31'd0, en_a}, 32'd1);
        chk("R7 keep-on follows hw request", {31'd0, en_k}, 32'd1);
        hw_run = 1'b0;
        @(negedge clk);
        chk("R4 hw release closes gate", {31'd0, en_a}, 32'd0);
        @(negedge clk);
        @(negedge clk);
        chk("R5 status follows hw gate", {31'd0, rd_a[1]}, 32'd0);
    endtask

    task automatic t_mode_switch;
        hw_run = 1'b1;
        reg_write(32'h4);
        @(negedge clk);
        chk("R9 to sw mode uses enable bit", {31'd0, en_a}, 32'd0);
        reg_write(32'h0);
        @(negedge clk);
        chk("R9 to hw mode uses request", {31'd0, en_a}, 32'd1);
        hw_run = 1'b0;
        reg_write(32'h5);
        @(negedge clk);
        chk("R9 back to sw enabled", {31'd0, en_a}, 32'd1);
    endtask

    task automatic t_ungated;
        chk("R8 gateless open", {31'd0, en_g}, 32'd1);
        hw_run = 1'b0;
        reg_write(32'h4);
        @(negedge clk);
        chk("R8 gateless ignores sw off", {31'd0, en_g}, 32'd1);
        reg_write(32'h0);
        @(negedge clk);
        chk("R8 gateless ignores hw idle", {31'd0, en_g}, 32'd1);
        @(negedge clk);
        @(negedge clk);
        chk("R8 gateless status open", {31'd0, rd_g[1]}, 32'd1);
        reg_write(32'h5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sw_off_on();
        t_status_ignored();
        t_hw_mode();
        t_mode_switch();
        t_ungated();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule